// File: doc/BRIEF.md
# USB Frame Schedule List Walker

This block walks a USB host controller's transfer schedule once per frame. On each frame tick it reads the entry for the current frame number from a frame list in memory. From there it follows link pointers through isochronous transfer descriptors and through queue heads. Each queue head holds a chain of descriptors.

Every descriptor it reaches goes to an external status updater, which reports one of four outcomes. Changed control words are written back to memory. Queue element links advance as descriptors complete.

The walker keeps at most one transaction outstanding. That transaction is either queued or isochronous. A later completion signal finalizes it through the same updater path.

Top module: `frameWalker`

## Requirements
- R1: After reset, frameNum is 0, no memory or updater request is raised, pendBusy is 0 and intCause is 0.
- R2: The frame-list entry is read at (flBase with bits 1:0 cleared) + 4 × frameNum[9:0]. After each frame walk, frameDone pulses for one cycle and frameNum advances by one modulo 2048.
- R3: A link with bit 0 set ends the list. Bit 1 set marks the target as a queue head. Every pointer is used with its low 4 bits cleared, so each memory address is word aligned.
- R4: A descriptor holds its link at +0, control at +4 and token at +8. Control is written back to +4 only when the updater returns a different value. memReq holds with a stable address until memAck.
- R5: A queue head holds its next-queue link at +0 and its element link at +4. When a descriptor completes, its link is written to the element link. The walk stays in the same queue only when that new link has bit 2 (depth) set. Otherwise it follows the queue head's +0 link.
- R6: At most MAX_TD descriptors are handed over per queue in one frame.
- R7: updResult encodes 0 = done, 1 = not done (move on), 2 = pending, 3 = stop. A stop result skips the rest of the frame, but the frame still completes and counts. updReq holds until updAck.
- R8: While a transaction is pending, no other descriptor is handed to the updater during a frame walk. Queues are passed over, and isochronous descriptors are stepped past.
- R9: A queued transaction still pending at the next frame tick is cancelled. cancelPend pulses and pendBusy falls. A pending isochronous transaction survives the tick.
- R10: An asyncDone while an isochronous transaction is pending re-reads the recorded frame-list entry and hands the descriptor over with updComplete = 1. On a done result, the descriptor's link is written into that entry and pendBusy clears.
- R11: intCause takes the OR of all updIntMask values seen since the previous frame end. It updates in the cycle after frameDone and then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameTick | input | 1 | Start-of-frame pulse |
| flBase | input | 32 | Frame list base address |
| asyncDone | input | 1 | Pending transaction has completed |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory access done |
| updReq | output | 1 | Descriptor offered to updater |
| updCtrl | output | 32 | Descriptor control word |
| updToken | output | 32 | Descriptor token word |
| updIsoch | output | 1 | Descriptor came from the frame list directly |
| updComplete | output | 1 | Offer finalizes the pending transaction |
| updAck | input | 1 | Updater result valid |
| updResult | input | 2 | Updater outcome code |
| updNewCtrl | input | 32 | Updated control word |
| updIntMask | input | 2 | Interrupt causes raised by the updater |
| frameNum | output | 11 | Current frame number |
| frameDone | output | 1 | Frame walk finished |
| intCause | output | 2 | Interrupt causes of the last frame |
| cancelPend | output | 1 | Pending queued transaction dropped |
| pendBusy | output | 1 | A transaction is outstanding |

## Verification
The hardest situation to reach from the ports is a pending isochronous transaction meeting both a frame tick and a late completion. This requires a frame in which the updater answers "pending" for an isochronous descriptor, and a following descriptor in the same chain that must be stepped past unseen. The bench reaches it by giving that descriptor's token a pending code in its updater model. It then ticks a frame and checks that nothing is cancelled. Next it rewrites the code to "done" and pulses asyncDone, then compares the frame-list entry and the descriptor control in its memory model against values derived from the layout. A 2042-frame sweep from frame 7 through the 2048 wrap confirms that one frame-list slot is visited at frames 1024 and 0.

// File: rtl/fwPkg.sv
package fwPkg;

  typedef enum logic [3:0] {
    A_ENTRY, A_QH, A_QHEL, A_TD, A_TD4, A_TD8, A_PEND, A_PEND4
  } addrSel_t;

  typedef enum logic {W_CTRL, W_TDLINK} wSel_t;

  localparam logic [1:0] RES_DONE    = 2'd0;
  localparam logic [1:0] RES_NOTDONE = 2'd1;
  localparam logic [1:0] RES_PEND    = 2'd2;
  localparam logic [1:0] RES_STOP    = 2'd3;

  typedef struct packed {
    logic     memReq;
    logic     memWe;
    addrSel_t addrSel;
    wSel_t    wSel;
    logic     ldEntry;
    logic     ldLinkRd;
    logic     ldLinkTd;
    logic     ldQh;
    logic     ldEl;
    logic     ldElTd;
    logic     ldTdFromLink;
    logic     ldTdFromEl;
    logic     ldTdLink;
    logic     ldTdCtrl;
    logic     ldTdToken;
    logic     ldNew;
    logic     cntLoad;
    logic     cntDec;
    logic     incFrame;
    logic     setPendQ;
    logic     setPendI;
    logic     clrPend;
  } strobe_t;

  typedef struct packed {
    logic linkTerm;
    logic linkQh;
    logic elTerm;
    logic elQh;
    logic elDepth;
    logic cntZero;
    logic pendAny;
    logic pendIso;
    logic ctrlChanged;
  } status_t;

endpackage

// File: rtl/fwData.sv
module fwData
  import fwPkg::*;
#(
  parameter int MAX_TD = 16,
  parameter int FN_W   = 11
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [31:0]     flBase,
  input  logic [31:0]     memRdata,
  input  logic [31:0]     updNewCtrl,
  input  logic [1:0]      updIntMask,
  input  strobe_t         st,
  output logic [31:0]     memAddr,
  output logic [31:0]     memWdata,
  output logic [31:0]     updCtrl,
  output logic [31:0]     updToken,
  output logic [FN_W-1:0] frameNum,
  output logic [1:0]      intCause,
  output logic            pendBusy,
  output status_t         stat
);
  localparam int IDX_W = FN_W - 1;
  localparam int CNT_W = $clog2(MAX_TD + 1);
  localparam logic [31:0] PTR_MASK = ~32'hF;

  logic [31:0] entryAddr, link, qhAddr, el, tdAddr;
  logic [31:0] tdLink, tdCtrl, tdToken, newCtrl, pendAddr;
  logic [CNT_W-1:0] tdCnt;
  logic [1:0] intAcc;
  logic pendV, pendIso;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryAddr <= '0; link <= '0; qhAddr <= '0; el <= '0; tdAddr <= '0;
      tdLink <= '0; tdCtrl <= '0; tdToken <= '0; newCtrl <= '0;
      pendAddr <= '0; tdCnt <= '0; intAcc <= '0; intCause <= '0;
      pendV <= 1'b0; pendIso <= 1'b0; frameNum <= '0;
    end else begin
      if (st.ldEntry)
        entryAddr <= (flBase & ~32'h3) +
                     {{(30-IDX_W){1'b0}}, frameNum[IDX_W-1:0], 2'b00};
      if (st.ldLinkRd)      link   <= memRdata;
      else if (st.ldLinkTd) link   <= tdLink;
      if (st.ldQh)          qhAddr <= link & PTR_MASK;
      if (st.ldEl)          el     <= memRdata;
      else if (st.ldElTd)   el     <= tdLink;
      if (st.ldTdFromLink)  tdAddr <= link & PTR_MASK;
      else if (st.ldTdFromEl) tdAddr <= el & PTR_MASK;
      if (st.ldTdLink)  tdLink  <= memRdata;
      if (st.ldTdCtrl)  tdCtrl  <= memRdata;
      if (st.ldTdToken) tdToken <= memRdata;
      if (st.ldTdCtrl)  newCtrl <= memRdata;
      else if (st.ldNew) newCtrl <= updNewCtrl;
      if (st.cntLoad)      tdCnt <= CNT_W'(MAX_TD);
      else if (st.cntDec && tdCnt != '0) tdCnt <= tdCnt - 1'b1;
      if (st.incFrame) begin
        frameNum <= frameNum + 1'b1;
        intCause <= intAcc;
        intAcc   <= '0;
      end else if (st.ldNew) begin
        intAcc <= intAcc | updIntMask;
      end
      if (st.setPendQ) begin
        pendV <= 1'b1; pendIso <= 1'b0; pendAddr <= qhAddr;
      end else if (st.setPendI) begin
        pendV <= 1'b1; pendIso <= 1'b1; pendAddr <= entryAddr;
      end else if (st.clrPend) begin
        pendV <= 1'b0;
      end
    end
  end

  always_comb begin
    case (st.addrSel)
      A_ENTRY: memAddr = entryAddr;
      A_QH:    memAddr = qhAddr;
      A_QHEL:  memAddr = qhAddr + 32'd4;
      A_TD:    memAddr = tdAddr;
      A_TD4:   memAddr = tdAddr + 32'd4;
      A_TD8:   memAddr = tdAddr + 32'd8;
      A_PEND:  memAddr = pendAddr;
      default: memAddr = pendAddr + 32'd4;
    endcase
    memWdata = (st.wSel == W_CTRL) ? newCtrl : tdLink;
  end

  assign updCtrl  = tdCtrl;
  assign updToken = tdToken;
  assign pendBusy = pendV;

  assign stat.linkTerm    = link[0];
  assign stat.linkQh      = link[1];
  assign stat.elTerm      = el[0];
  assign stat.elQh        = el[1];
  assign stat.elDepth     = el[2];
  assign stat.cntZero     = (tdCnt == '0);
  assign stat.pendAny     = pendV;
  assign stat.pendIso     = pendIso;
  assign stat.ctrlChanged = (newCtrl != tdCtrl);

endmodule

// File: rtl/fwCtrl.sv
module fwCtrl
  import fwPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameTick,
  input  logic       asyncDone,
  input  logic       memAck,
  input  logic       updAck,
  input  logic [1:0] updResult,
  input  status_t    stat,
  output strobe_t    st,
  output logic       updReq,
  output logic       updIsoch,
  output logic       updComplete,
  output logic       frameDone,
  output logic       cancelPend
);
  typedef enum logic [4:0] {
    S_IDLE, S_RD_ENTRY, S_DISP, S_RD_QHEL, S_QCHK, S_RD_TDL, S_RD_TDC,
    S_RD_TDT, S_UPD, S_WRC, S_POST, S_WR_EL, S_DEPTH, S_RD_QHNX, S_END,
    S_C_RD, S_C_SET, S_C_WR
  } state_t;

  state_t state, nxt;
  logic inQ, inQN, comp, compN, tickSeen, doneSeen, tickUse, doneUse;
  logic [1:0] res, resN;

  always_comb begin
    st = '0;
    nxt = state; inQN = inQ; compN = comp; resN = res;
    tickUse = 1'b0; doneUse = 1'b0;
    updReq = 1'b0; frameDone = 1'b0; cancelPend = 1'b0;
    case (state)
      S_IDLE: begin
        if (doneSeen && stat.pendAny) begin
          doneUse = 1'b1; compN = 1'b1; nxt = S_C_RD;
        end else if (tickSeen) begin
          tickUse = 1'b1; compN = 1'b0; st.ldEntry = 1'b1;
          if (stat.pendAny && !stat.pendIso) begin
            st.clrPend = 1'b1; cancelPend = 1'b1;
          end
          nxt = S_RD_ENTRY;
        end
      end
      S_RD_ENTRY: begin
        st.memReq = 1'b1; st.addrSel = A_ENTRY;
        if (memAck) begin st.ldLinkRd = 1'b1; nxt = S_DISP; end
      end
      S_DISP: begin
        if (stat.linkTerm) nxt = S_END;
        else if (stat.linkQh) begin
          st.ldQh = 1'b1; inQN = 1'b1; nxt = S_RD_QHEL;
        end else begin
          st.ldTdFromLink = 1'b1; inQN = 1'b0; nxt = S_RD_TDL;
        end
      end
      S_RD_QHEL: begin
        st.memReq = 1'b1; st.addrSel = A_QHEL;
        if (memAck) begin st.ldEl = 1'b1; st.cntLoad = 1'b1; nxt = S_QCHK; end
      end
      S_QCHK: begin
        if (stat.pendAny || stat.elTerm || stat.elQh || stat.cntZero)
          nxt = S_RD_QHNX;
        else begin st.ldTdFromEl = 1'b1; nxt = S_RD_TDL; end
      end
      S_RD_TDL: begin
        st.memReq = 1'b1; st.addrSel = A_TD;
        if (memAck) begin
          st.ldTdLink = 1'b1;
          if (!inQ && stat.pendAny && !comp) begin
            st.ldLinkRd = 1'b1; nxt = S_DISP;
          end else nxt = S_RD_TDC;
        end
      end
      S_RD_TDC: begin
        st.memReq = 1'b1; st.addrSel = A_TD4;
        if (memAck) begin st.ldTdCtrl = 1'b1; nxt = S_RD_TDT; end
      end
      S_RD_TDT: begin
        st.memReq = 1'b1; st.addrSel = A_TD8;
        if (memAck) begin st.ldTdToken = 1'b1; nxt = S_UPD; end
      end
      S_UPD: begin
        updReq = 1'b1;
        if (updAck) begin
          st.ldNew = 1'b1; resN = updResult;
          st.cntDec = inQ && !comp;
          nxt = S_WRC;
        end
      end
      S_WRC: begin
        if (stat.ctrlChanged) begin
          st.memReq = 1'b1; st.memWe = 1'b1; st.addrSel = A_TD4; st.wSel = W_CTRL;
          if (memAck) nxt = S_POST;
        end else nxt = S_POST;
      end
      S_POST: begin
        if (comp) begin
          if (res == RES_PEND) nxt = S_IDLE;
          else begin
            st.clrPend = 1'b1;
            nxt = (res == RES_DONE) ? S_C_WR : S_IDLE;
          end
        end else if (res == RES_STOP) nxt = S_END;
        else if (!inQ) begin
          st.setPendI = (res == RES_PEND);
          st.ldLinkTd = 1'b1; nxt = S_DISP;
        end else if (res == RES_DONE) nxt = S_WR_EL;
        else begin
          st.setPendQ = (res == RES_PEND);
          nxt = S_RD_QHNX;
        end
      end
      S_WR_EL: begin
        st.memReq = 1'b1; st.memWe = 1'b1; st.addrSel = A_QHEL; st.wSel = W_TDLINK;
        if (memAck) begin st.ldElTd = 1'b1; nxt = S_DEPTH; end
      end
      S_DEPTH: nxt = stat.elDepth ? S_QCHK : S_RD_QHNX;
      S_RD_QHNX: begin
        st.memReq = 1'b1; st.addrSel = A_QH;
        if (memAck) begin st.ldLinkRd = 1'b1; nxt = S_DISP; end
      end
      S_END: begin
        frameDone = 1'b1; st.incFrame = 1'b1; nxt = S_IDLE;
      end
      S_C_RD: begin
        st.memReq = 1'b1;
        st.addrSel = stat.pendIso ? A_PEND : A_PEND4;
        inQN = !stat.pendIso;
        if (memAck) begin
          st.ldLinkRd = stat.pendIso; st.ldEl = !stat.pendIso; nxt = S_C_SET;
        end
      end
      S_C_SET: begin
        st.ldTdFromLink = stat.pendIso; st.ldTdFromEl = !stat.pendIso;
        nxt = S_RD_TDL;
      end
      S_C_WR: begin
        st.memReq = 1'b1; st.memWe = 1'b1; st.wSel = W_TDLINK;
        st.addrSel = stat.pendIso ? A_PEND : A_PEND4;
        if (memAck) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; inQ <= 1'b0; comp <= 1'b0; res <= '0;
      tickSeen <= 1'b0; doneSeen <= 1'b0;
    end else begin
      state <= nxt; inQ <= inQN; comp <= compN; res <= resN;
      tickSeen <= frameTick | (tickSeen & !tickUse);
      doneSeen <= asyncDone | (doneSeen & !doneUse & stat.pendAny);
    end
  end

  assign updIsoch    = !inQ;
  assign updComplete = comp;

endmodule

// File: rtl/frameWalker.sv
module frameWalker
  import fwPkg::*;
#(
  parameter int MAX_TD = 16,
  parameter int FN_W   = 11
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameTick,
  input  logic [31:0]     flBase,
  input  logic            asyncDone,
  output logic            memReq,
  output logic            memWe,
  output logic [31:0]     memAddr,
  output logic [31:0]     memWdata,
  input  logic [31:0]     memRdata,
  input  logic            memAck,
  output logic            updReq,
  output logic [31:0]     updCtrl,
  output logic [31:0]     updToken,
  output logic            updIsoch,
  output logic            updComplete,
  input  logic            updAck,
  input  logic [1:0]      updResult,
  input  logic [31:0]     updNewCtrl,
  input  logic [1:0]      updIntMask,
  output logic [FN_W-1:0] frameNum,
  output logic            frameDone,
  output logic [1:0]      intCause,
  output logic            cancelPend,
  output logic            pendBusy
);
  strobe_t st;
  status_t stat;

  fwCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .asyncDone(asyncDone),
    .memAck(memAck), .updAck(updAck), .updResult(updResult), .stat(stat),
    .st(st), .updReq(updReq), .updIsoch(updIsoch), .updComplete(updComplete),
    .frameDone(frameDone), .cancelPend(cancelPend)
  );

  fwData #(.MAX_TD(MAX_TD), .FN_W(FN_W)) data_i (
    .clk(clk), .rstN(rstN), .flBase(flBase), .memRdata(memRdata),
    .updNewCtrl(updNewCtrl), .updIntMask(updIntMask), .st(st),
    .memAddr(memAddr), .memWdata(memWdata), .updCtrl(updCtrl),
    .updToken(updToken), .frameNum(frameNum), .intCause(intCause),
    .pendBusy(pendBusy), .stat(stat)
  );

  assign memReq = st.memReq;
  assign memWe  = st.memWe;

endmodule

// File: rtl/fwChk.sv
module fwChk #(
  parameter int FN_W = 11
) (
  input logic            clk,
  input logic            rstN,
  input logic            memReq,
  input logic            memWe,
  input logic [31:0]     memAddr,
  input logic            memAck,
  input logic            updReq,
  input logic            updAck,
  input logic            updComplete,
  input logic [FN_W-1:0] frameNum,
  input logic            frameDone,
  input logic            cancelPend,
  input logic            pendBusy
);
  a_r2_frame_step: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> frameNum == FN_W'($past(frameNum) + 1'b1));

  a_r2_frame_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameDone |=> $stable(frameNum));

  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00);

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  a_r7_upd_hold: assert property (@(posedge clk) disable iff (!rstN)
    updReq && !updAck |=> updReq);

  a_r8_single_pending: assert property (@(posedge clk) disable iff (!rstN)
    updReq |-> (!pendBusy || updComplete));

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    updReq |-> !memReq);

  a_r9_cancel_clears: assert property (@(posedge clk) disable iff (!rstN)
    cancelPend |=> !pendBusy);
endmodule

bind frameWalker fwChk #(.FN_W(FN_W)) chk_i (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memAck(memAck), .updReq(updReq), .updAck(updAck), .updComplete(updComplete),
  .frameNum(frameNum), .frameDone(frameDone), .cancelPend(cancelPend),
  .pendBusy(pendBusy)
);

// File: tb/frameWalker_tb_top.sv
module frameWalker_tb_top;
  localparam int CLK_NS = 10;
  localparam int MAX_TD = 3;

  logic clk = 1'b0, rstN = 1'b0, frameTick = 1'b0, asyncDone = 1'b0;
  logic [31:0] flBase = 32'h0;
  logic memReq, memWe, memAck = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata = '0;
  logic updReq, updIsoch, updComplete, updAck = 1'b0;
  logic [31:0] updCtrl, updToken, updNewCtrl = '0;
  logic [1:0] updResult = '0, updIntMask = '0, intCause;
  logic [10:0] frameNum;
  logic frameDone, cancelPend, pendBusy;

  logic [31:0] mem [0:2047];
  logic [1:0] resTab [0:31];
  int callTok [0:63];
  int callComp [0:63];
  int callN = 0, tok17 = 0, doneCnt = 0, cancelCnt = 0, writeCnt = 0;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  frameWalker #(.MAX_TD(MAX_TD), .FN_W(11)) dut_i (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .flBase(flBase),
    .asyncDone(asyncDone), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .updReq(updReq), .updCtrl(updCtrl), .updToken(updToken),
    .updIsoch(updIsoch), .updComplete(updComplete), .updAck(updAck),
    .updResult(updResult), .updNewCtrl(updNewCtrl), .updIntMask(updIntMask),
    .frameNum(frameNum), .frameDone(frameDone), .intCause(intCause),
    .cancelPend(cancelPend), .pendBusy(pendBusy)
  );

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin
        mem[memAddr[12:2]] <= memWdata;
        writeCnt <= writeCnt + 1;
      end else memRdata <= mem[memAddr[12:2]];
    end
  end

  // updater model: result from table, done sets control bit 0
  always @(posedge clk) begin
    updAck <= 1'b0;
    if (updReq && !updAck) begin
      updAck <= 1'b1;
      updResult <= resTab[updToken[4:0]];
      updNewCtrl <= (resTab[updToken[4:0]] == 2'd0) ? (updCtrl | 32'h1) : updCtrl;
      updIntMask <= updCtrl[25:24];
      if (callN < 64) begin
        callTok[callN] <= int'(updToken);
        callComp[callN] <= int'(updComplete);
      end
      callN <= callN + 1;
      if (updToken == 32'd17) tok17 <= tok17 + 1;
    end
    if (frameDone) doneCnt <= doneCnt + 1;
    if (cancelPend) cancelCnt <= cancelCnt + 1;
  end

  function automatic logic [31:0] tdA(input int k);
    return 32'h1000 + 32'(16 * k);
  endfunction
  function automatic logic [31:0] qhA(input int q);
    return 32'h1800 + 32'(16 * q);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setTd(input int k, input logic [31:0] lnk, input logic [31:0] ctl);
    mem[tdA(k) >> 2]       <= lnk;
    mem[(tdA(k) >> 2) + 1] <= ctl;
    mem[(tdA(k) >> 2) + 2] <= 32'(k);
    mem[(tdA(k) >> 2) + 3] <= 32'h0;
  endtask

  task automatic setQh(input int q, input logic [31:0] head, input logic [31:0] elk);
    mem[qhA(q) >> 2]       <= head;
    mem[(qhA(q) >> 2) + 1] <= elk;
  endtask

  task automatic tick();
    int prev;
    prev = doneCnt;
    @(negedge clk); frameTick = 1'b1;
    @(negedge clk); frameTick = 1'b0;
    while (doneCnt == prev) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      finish();
    end
  end

  initial begin
    int base, w0;
    for (int i = 0; i < 2048; i++) mem[i] <= 32'h1;
    for (int i = 0; i < 32; i++) resTab[i] <= 2'd1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 frameNum", 32'(frameNum), 0);
    chk("R1 memReq", 32'(memReq), 0);
    chk("R1 updReq", 32'(updReq), 0);
    chk("R1 pendBusy", 32'(pendBusy), 0);
    chk("R1 intCause", 32'(intCause), 0);

    // Frame 0: iso TD then two queues, depth and breadth
    mem[0] <= tdA(0);
    setTd(0, qhA(0) | 32'h2, 32'h0100_0000); resTab[0] <= 2'd0;
    setQh(0, qhA(1) | 32'h2, tdA(1));
    setTd(1, tdA(2) | 32'h4, 0); resTab[1] <= 2'd0;
    setTd(2, tdA(3), 0);         resTab[2] <= 2'd0;
    setTd(3, 32'h1, 0);          resTab[3] <= 2'd0;
    setQh(1, 32'h1, tdA(4));
    setTd(4, 32'h1, 0);          resTab[4] <= 2'd1;
    base = callN; w0 = writeCnt;
    tick();
    chk("R2 frameNum after frame 0", 32'(frameNum), 1);
    chk("R3 call count", 32'(callN - base), 4);
    chk("R3 iso first", 32'(callTok[base]), 0);
    chk("R5 depth second", 32'(callTok[base+1]), 1);
    chk("R5 depth third", 32'(callTok[base+2]), 2);
    chk("R5 breadth next queue", 32'(callTok[base+3]), 4);
    chk("R4 TD0 ctrl written", mem[(tdA(0) >> 2) + 1], 32'h0100_0001);
    chk("R4 TD2 ctrl written", mem[(tdA(2) >> 2) + 1], 32'h1);
    chk("R4 TD4 ctrl untouched", mem[(tdA(4) >> 2) + 1], 32'h0);
    chk("R4 write count", 32'(writeCnt - w0), 5);
    chk("R5 QH0 element link", mem[(qhA(0) >> 2) + 1], tdA(3));
    chk("R5 QH1 element link", mem[(qhA(1) >> 2) + 1], tdA(4));
    chk("R11 intCause", 32'(intCause), 1);

    // Frame 1: per-queue bound
    mem[1] <= qhA(2) | 32'h2;
    setQh(2, 32'h1, tdA(5));
    for (int k = 5; k < 10; k++) begin
      setTd(k, tdA(k + 1) | 32'h4, 0); resTab[k] <= 2'd0;
    end
    base = callN;
    tick();
    chk("R6 bounded count", 32'(callN - base), MAX_TD);
    chk("R6 element link after bound", mem[(qhA(2) >> 2) + 1], tdA(8) | 32'h4);
    chk("R11 intCause cleared", 32'(intCause), 0);

    // Frame 2: stop result
    mem[2] <= qhA(3) | 32'h2;
    setQh(3, qhA(4) | 32'h2, tdA(10));
    setTd(10, 32'h1, 0); resTab[10] <= 2'd3;
    setQh(4, 32'h1, tdA(11));
    setTd(11, 32'h1, 0); resTab[11] <= 2'd0;
    base = callN;
    tick();
    chk("R7 stop single call", 32'(callN - base), 1);
    chk("R7 later TD untouched", mem[(tdA(11) >> 2) + 1], 0);
    chk("R7 frame counted", 32'(frameNum), 3);

    // Frame 3: queued pending, later queue waits
    mem[3] <= tdA(12);
    setTd(12, qhA(5) | 32'h2, 0); resTab[12] <= 2'd1;
    setQh(5, qhA(6) | 32'h2, tdA(13));
    setTd(13, 32'h1, 0); resTab[13] <= 2'd2;
    setQh(6, 32'h1, tdA(14));
    setTd(14, 32'h1, 0); resTab[14] <= 2'd0;
    base = callN;
    tick();
    chk("R8 calls before pending", 32'(callN - base), 2);
    chk("R8 pending token", 32'(callTok[base+1]), 13);
    chk("R8 pendBusy", 32'(pendBusy), 1);
    chk("R8 waiting queue untouched", mem[(tdA(14) >> 2) + 1], 0);
    w0 = cancelCnt;
    tick();
    chk("R9 cancel pulse", 32'(cancelCnt - w0), 1);
    chk("R9 pending dropped", 32'(pendBusy), 0);

    // Frame 5: isochronous pending and completion
    mem[5] <= tdA(15);
    setTd(15, tdA(16), 0); resTab[15] <= 2'd2;
    setTd(16, 32'h1, 0);   resTab[16] <= 2'd0;
    base = callN;
    tick();
    chk("R8 iso skip while pending", 32'(callN - base), 1);
    chk("R8 skipped TD untouched", mem[(tdA(16) >> 2) + 1], 0);
    w0 = cancelCnt;
    tick();
    chk("R9 iso not cancelled", 32'(cancelCnt - w0), 0);
    chk("R9 iso still pending", 32'(pendBusy), 1);
    resTab[15] <= 2'd0;
    base = callN;
    @(negedge clk); asyncDone = 1'b1;
    @(negedge clk); asyncDone = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10 completion call", 32'(callN - base), 1);
    chk("R10 completion flag", 32'(callComp[base]), 1);
    chk("R10 TD ctrl finalized", mem[(tdA(15) >> 2) + 1], 32'h1);
    chk("R10 entry relinked", mem[5], tdA(16));
    chk("R10 pending cleared", 32'(pendBusy), 0);

    // Sweep through wrap: only entry 0 holds a TD
    for (int i = 0; i < 1024; i++) mem[i] <= 32'h1;
    mem[0] <= tdA(17);
    setTd(17, 32'h1, 0); resTab[17] <= 2'd1;
    chk("R2 sweep start", 32'(frameNum), 7);
    for (int i = 0; i < 2042; i++) begin
      int expFn;
      expFn = (int'(frameNum) + 1) % 2048;
      tick();
      chk("R2 frame step", 32'(frameNum), 32'(expFn));
    end
    chk("R2 entry index wraps at 1024", 32'(tok17), 2);
    finish();
  end
endmodule